// File: doc/BRIEF.md
# Integer ALU with Branch Compare Flags

This is a purely combinational integer arithmetic and logic unit for the execute stage of a 32-bit in-order integer pipeline. Each cycle the stage presents a 4-bit operation code and two operands. The unit returns a 32-bit result and three compare flags: less-than, greater-than and zero. The branch-decision logic in the execute stage reads these flags.

It covers the bitwise logic operations, addition, subtraction, the three shift kinds, and the signed and unsigned set-if-less operations. There are two subtract codes. Both give the same difference on the result port. One of them computes the ordering flags with a signed comparison and the other with an unsigned comparison. This lets one unit evaluate both the signed and the unsigned conditional branches.

Top module: `int_alu`

## Requirements
- R1: Code 0000 gives A AND B, code 0001 gives A OR B, and code 0011 gives A XOR B on the result port.
- R2: Code 0010 gives A + B modulo 2^32.
- R3: Codes 0110 and 0111 both give A - B modulo 2^32 on the result port.
- R4: The shift amount is B[4:0]; the upper bits of B are ignored. The shifts are:
  - code 0100: logical left shift of A;
  - code 1000: logical right shift of A;
  - code 1100: arithmetic right shift of A, which copies A[31] into the vacated bits.
- R5: Code 1010 gives 1 when A < B as signed values and 0 otherwise. Code 0101 does the same with an unsigned comparison. Bits 31:1 of the result are always 0 for both codes.
- R6: For codes 0111 and 0101, lt_o and gt_o compare A against B as unsigned values. For every other code they compare as signed values. gt_o is high exactly when A is neither less than nor equal to B, so lt_o and gt_o are never high together.
- R7: zero_o is high exactly when all 32 result bits are 0.
- R8: The unused codes 1001, 1011, 1101, 1110 and 1111 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; its low 5 bits are the shift amount |
| result_o | output | 32 | Operation result |
| lt_o | output | 1 | A is less than B (signedness chosen by the code) |
| gt_o | output | 1 | A is greater than B (signedness chosen by the code) |
| zero_o | output | 1 | Result is all zeros |

## Verification
The embedded assertions check, on every input change, a set of structural properties:
- the ordering flags are mutually exclusive;
- a zero difference on either subtract code never comes with an ordering flag;
- set-if-less results are one bit wide;
- a zero shift amount passes the operand through;
- the unused codes give zero.

The actual values of the sums, differences, shifts and comparisons can only be shown by the bench. It sweeps every code over a grid of boundary and pseudo-random operands and compares each output against arithmetic computed in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_XOR  = 4'b0011,
    OP_SLL  = 4'b0100,
    OP_SLTU = 4'b0101,
    OP_SUBS = 4'b0110,
    OP_SUBU = 4'b0111,
    OP_SRL  = 4'b1000,
    OP_SLT  = 4'b1010,
    OP_SRA  = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic_fn_e        fn_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_addsub_cmp.sv
module alu_addsub_cmp #(
  parameter int WIDTH = 32
) (
  input  logic             sub_i,
  input  logic             unsigned_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             slt_o,
  output logic             ult_o,
  output logic             lt_o,
  output logic             gt_o
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   add_full;
  logic [WIDTH:0]   dif_full;
  logic             equal;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign add_full = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o    = add_full[WIDTH-1:0];

  // dedicated difference path so the compare is valid on every code
  assign dif_full = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
  assign equal    = (a_i == b_i);
  assign ult_o    = ~dif_full[WIDTH];
  assign slt_o    = (a_i[WIDTH-1] ^ b_i[WIDTH-1]) ? a_i[WIDTH-1] : dif_full[WIDTH-1];

  assign lt_o = unsigned_i ? ult_o : slt_o;
  assign gt_o = ~lt_o & ~equal;

  always_comb begin
    if (!$isunknown({a_i, b_i, unsigned_i})) begin
      AST_FLAG_EXCL: assert (!(lt_o && gt_o)); // R6
    end
  end

endmodule

// File: rtl/alu_barrel_shift.sv
module alu_barrel_shift #(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             left_i,
  input  logic             arith_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] y_o
);

  logic [WIDTH-1:0] stage [0:AMT_W];
  logic             fill;

  assign fill     = arith_i & a_i[WIDTH-1];
  assign stage[0] = a_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] shl;
    logic [WIDTH-1:0] shr;
    assign shl = {stage[k][WIDTH-1-S:0], {S{1'b0}}};
    assign shr = {{S{fill}}, stage[k][WIDTH-1:S]};
    assign stage[k+1] = amt_i[k] ? (left_i ? shl : shr) : stage[k];
  end

  assign y_o = stage[AMT_W];

  always_comb begin
    if (!$isunknown({amt_i, a_i, left_i, arith_i})) begin
      if (amt_i == '0) begin
        AST_SHIFT_ZERO_PASS: assert (y_o == a_i); // R4
      end
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             lt_o,
  output logic             gt_o,
  output logic             zero_o
);

  logic_fn_e        lg_fn;
  logic [WIDTH-1:0] lg_y;
  logic             as_sub;
  logic             as_uns;
  logic [WIDTH-1:0] as_sum;
  logic             as_slt;
  logic             as_ult;
  logic             sh_left;
  logic             sh_arith;
  logic [WIDTH-1:0] sh_y;
  logic             is_sub;
  logic             is_set;
  logic             is_legal;

  always_comb begin
    lg_fn    = LG_AND;
    as_sub   = 1'b0;
    as_uns   = 1'b0;
    sh_left  = 1'b0;
    sh_arith = 1'b0;
    is_sub   = 1'b0;
    is_set   = 1'b0;
    is_legal = 1'b1;
    result_o = '0;
    unique case (op_i)
      OP_AND:  begin lg_fn = LG_AND; result_o = lg_y; end
      OP_OR:   begin lg_fn = LG_OR;  result_o = lg_y; end
      OP_XOR:  begin lg_fn = LG_XOR; result_o = lg_y; end
      OP_ADD:  result_o = as_sum;
      OP_SUBS: begin as_sub = 1'b1; is_sub = 1'b1; result_o = as_sum; end
      OP_SUBU: begin as_sub = 1'b1; as_uns = 1'b1; is_sub = 1'b1; result_o = as_sum; end
      OP_SLT:  begin is_set = 1'b1; result_o = {{(WIDTH-1){1'b0}}, as_slt}; end
      OP_SLTU: begin as_uns = 1'b1; is_set = 1'b1; result_o = {{(WIDTH-1){1'b0}}, as_ult}; end
      OP_SLL:  begin sh_left = 1'b1; result_o = sh_y; end
      OP_SRL:  result_o = sh_y;
      OP_SRA:  begin sh_arith = 1'b1; result_o = sh_y; end
      default: is_legal = 1'b0;
    endcase
  end

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .fn_i (lg_fn),
    .a_i  (a_i),
    .b_i  (b_i),
    .y_o  (lg_y)
  );

  alu_addsub_cmp #(.WIDTH(WIDTH)) u_addsub (
    .sub_i      (as_sub),
    .unsigned_i (as_uns),
    .a_i        (a_i),
    .b_i        (b_i),
    .sum_o      (as_sum),
    .slt_o      (as_slt),
    .ult_o      (as_ult),
    .lt_o       (lt_o),
    .gt_o       (gt_o)
  );

  alu_barrel_shift #(.WIDTH(WIDTH)) u_shift (
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .amt_i   (b_i[AMT_W-1:0]),
    .a_i     (a_i),
    .y_o     (sh_y)
  );

  assign zero_o = (result_o == '0);

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i})) begin
      if (is_sub && zero_o) begin
        AST_SUB_ZERO_NO_ORDER: assert (!lt_o && !gt_o); // R7
      end
      if (is_set) begin
        AST_SET_ONE_BIT: assert (result_o[WIDTH-1:1] == '0); // R5
      end
      if (!is_legal) begin
        AST_UNUSED_ZERO: assert (zero_o); // R8
      end
    end
  end

endmodule

// File: tb/test_int_alu.sv
module test_int_alu;

  logic        clk;
  logic [3:0]  op;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] res;
  logic        lt;
  logic        gt;
  logic        zf;
  int          n_chk;
  int          n_fail;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int_alu i_int_alu (
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .result_o (res),
    .lt_o     (lt),
    .gt_o     (gt),
    .zero_o   (zf)
  );

  function automatic logic [31:0] pick(input int idx, input logic [31:0] seed);
    case (idx)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_001F;
      6: return 32'h0000_0020;
      7: return 32'hFFFF_FFE5;
      8: return 32'h8000_0001;
      9: return 32'h1234_5678;
      default: return seed;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'b0000, 4'b0001, 4'b0011: return "R1";
      4'b0010: return "R2";
      4'b0110, 4'b0111: return "R3";
      4'b0100, 4'b1000, 4'b1100: return "R4";
      4'b1010, 4'b0101: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check_one(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] exp_r;
    logic        exp_lt;
    logic        exp_gt;
    logic        uns;
    int          sh;
    @(negedge clk);
    op = o; a = x; b = y;
    #2;
    sh = int'(y % 32);
    case (o)
      4'b0000: exp_r = x & y;
      4'b0001: exp_r = x | y;
      4'b0011: exp_r = x ^ y;
      4'b0010: exp_r = x + y;
      4'b0110, 4'b0111: exp_r = x - y;
      4'b0100: exp_r = x << sh;
      4'b1000: exp_r = x >> sh;
      4'b1100: exp_r = $signed(x) >>> sh;
      4'b1010: exp_r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b0101: exp_r = (x < y) ? 32'd1 : 32'd0;
      default: exp_r = 32'd0;
    endcase
    uns    = (o == 4'b0111) || (o == 4'b0101);
    exp_lt = uns ? (x < y) : ($signed(x) < $signed(y));
    exp_gt = uns ? (x > y) : ($signed(x) > $signed(y));
    n_chk++;
    if (res !== exp_r) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h result=%h expected=%h", req_of(o), o, x, y, res, exp_r);
    end
    n_chk++;
    if (lt !== exp_lt || gt !== exp_gt) begin
      n_fail++;
      $display("FAIL R6 op=%b a=%h b=%h lt/gt=%b%b expected=%b%b", o, x, y, lt, gt, exp_lt, exp_gt);
    end
    n_chk++;
    if (zf !== (exp_r == 32'd0)) begin
      n_fail++;
      $display("FAIL R7 op=%b a=%h b=%h zero=%b expected=%b", o, x, y, zf, exp_r == 32'd0);
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    n_chk  = 0;
    n_fail = 0;
    op = 4'b0000; a = '0; b = '0;
    lfsr = 32'hACE1_2468;
    // idle state: all-zero inputs give zero result and zero flag (R7)
    #2;
    n_chk++;
    if (res !== 32'd0 || zf !== 1'b1) begin
      n_fail++;
      $display("FAIL R7 idle result=%h zero=%b expected=00000000 1", res, zf);
    end
    // full sweep: every code (R1..R8) over boundary and pseudo-random operands
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 14; i++) begin
        for (int j = 0; j < 14; j++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          check_one(4'(o), pick(i, lfsr), pick(j, {lfsr[15:0], lfsr[31:16]}));
        end
      end
    end
    // R4: upper bits of B ignored for shift amount
    check_one(4'b0100, 32'h0000_00F1, 32'hFFFF_FFE3);
    check_one(4'b1100, 32'h8000_0F00, 32'h0000_0104);
    // R3/R6: equal operands give zero with no ordering flag
    check_one(4'b0110, 32'h8000_0000, 32'h8000_0000);
    check_one(4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule